// File: doc/BRIEF.md
# Isolated Memory Region Access Filter

This block sits between the agents of a system and its memory and screens every memory transaction against a small table of protected address regions. Each region has a low bound and a high bound at 1 KiB granularity, and two permission masks with one bit per agent: one mask for reads and one for writes. A transaction whose address falls inside a region whose relevant mask does not grant the requesting agent is refused. A refused write never reaches memory. A refused read hands the agent all ones instead of the memory data. Each refusal produces a one-cycle violation pulse that the system uses to request a reset.

Software programs the regions through a simple register port. Each region owns four consecutive 32-bit registers in a fixed window. A one-way lock bit in each region's low-bound register freezes that region until the next reset. Regions may overlap, and any region that matches and denies an access refuses it. The pass, drop and replace decisions are combinational within the transaction cycle. The violation pulse is registered and appears one cycle after the refused transaction.

Top module: `imr_filter`

## Requirements
- R1: After reset every region reads back low bound 0, high bound 0, read mask 0xBFFFFFFF and write mask 0xFFFFFFFF. Region n occupies register indices REG_BASE+4n (low bound), +1 (high bound), +2 (read mask) and +3 (write mask), with REG_BASE = 0x40 by default.
- R2: In both bound registers only bits 23:2 (physical address bits 31:10) are stored. Bit 31 of the low-bound register is the lock bit. Every other bound bit (bits 30:24 and 1:0, and bit 31 of the high bound) reads back as 0.
- R3: A region matches address A when lo ≤ A[31:10] ≤ hi, where lo and hi are the stored 22-bit fields. The region therefore spans lo·1024 through hi·1024 + 0x3FF, both ends included.
- R4: An agent is granted by a region when the agent's one-hot bit is set in the region's read mask (for reads) or write mask (for writes). A valid write asserts mem_wr_en in the same cycle only if no matching region denies it. A refused write leaves mem_wr_en low.
- R5: A valid read that no matching region denies returns mem_rdata on rsp_rdata in the same cycle. A refused read returns 0xFFFFFFFF.
- R6: txn_violation is high for exactly one cycle, in the cycle after each refused transaction, and low after permitted transactions and idle cycles.
- R7: When regions overlap, an access is refused if any matching region denies it, even if another matching region grants it.
- R8: Writing a 1 to lock bit 31 of a region's low-bound register sets the lock. The lock stays set until reset. While it is set, writes to all four registers of that region are ignored. Other regions stay writable.
- R9: Regions in the reset state still cover the first 1 KiB block. Reads there by the agent on bit 30 are refused, and writes by that agent are allowed.
- R10: Register writes outside the window REG_BASE .. REG_BASE+4·NUM_REGIONS−1 change no region. Register reads outside the window return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | REG_ADDR_W | Register index for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Contents of the register at reg_addr (combinational) |
| txn_valid | input | 1 | A memory transaction is present this cycle |
| txn_write | input | 1 | 1 = write, 0 = read |
| txn_addr | input | 32 | Physical byte address of the transaction |
| txn_agent | input | 32 | One-hot agent identifier, same bit order as the masks |
| mem_rdata | input | DATA_W | Read data returned by memory |
| mem_wr_en | output | 1 | Write is forwarded to memory |
| rsp_rdata | output | DATA_W | Read data returned to the agent |
| txn_violation | output | 1 | One-cycle pulse after a refused transaction |

## Verification
The bench builds the block with its defaults: eight regions, a register window at 0x40 and 32-bit data. With these values the bench can reach the last register of the window (0x5F) and the first index past it (0x60). It also exercises six untouched regions that all overlap the first 1 KiB block in their reset state. The bench programs two regions that overlap partially, so that both edges of each range and the deny-wins rule are probed with single-block steps. A fifth region is pushed to the very top of the address space to test the upper limit of the bound field.

// File: rtl/imr_pkg.sv
// Shared constants and types for the isolated memory region filter.
// Assumes 32-bit physical addresses and 32-bit agent masks.
package imr_pkg;

    localparam int MASK_W   = 32;
    localparam int BOUND_W  = 22;          // address bits 31:10
    localparam int BLK_LSB  = 10;          // 1 KiB granularity
    localparam int LOCK_BIT = 31;

    localparam logic [MASK_W-1:0] RMASK_RST = 32'hBFFF_FFFF;
    localparam logic [MASK_W-1:0] WMASK_RST = 32'hFFFF_FFFF;

    // Word offset of a register inside a region's group of four
    typedef enum logic [1:0] {
        WORD_LO = 2'd0,
        WORD_HI = 2'd1,
        WORD_RD = 2'd2,
        WORD_WR = 2'd3
    } imr_word_e;

    typedef struct packed {
        logic               lock;
        logic [BOUND_W-1:0] lo;
        logic [BOUND_W-1:0] hi;
        logic [MASK_W-1:0]  rmask;
        logic [MASK_W-1:0]  wmask;
    } imr_region_t;

endpackage

// File: rtl/imr_region_regs.sv
// One protected region's configuration registers.
// Assumes wr_en is already qualified for this region. A set lock blocks
// every write to the region until reset.
module imr_region_regs
    import imr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  imr_word_e   wr_word,
    input  logic [31:0] wr_data,
    output imr_region_t cfg
);

    imr_region_t cfg_q;

    // Register update with lock protection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.lock  <= 1'b0;
            cfg_q.lo    <= '0;
            cfg_q.hi    <= '0;
            cfg_q.rmask <= RMASK_RST;
            cfg_q.wmask <= WMASK_RST;
        end else if (wr_en && !cfg_q.lock) begin
            case (wr_word)
                WORD_LO: begin
                    cfg_q.lo   <= wr_data[BOUND_W+1:2];
                    cfg_q.lock <= wr_data[LOCK_BIT];
                end
                WORD_HI: cfg_q.hi    <= wr_data[BOUND_W+1:2];
                WORD_RD: cfg_q.rmask <= wr_data;
                WORD_WR: cfg_q.wmask <= wr_data;
                default: ;
            endcase
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/imr_region_check.sv
// Address match and permission decode for one region.
// Assumes blk is the transaction address shifted right by 10.
module imr_region_check
    import imr_pkg::*;
(
    input  imr_region_t        cfg,
    input  logic [BOUND_W-1:0] blk,
    input  logic [MASK_W-1:0]  agent,
    input  logic               is_write,
    output logic               hit,
    output logic               deny
);

    logic [MASK_W-1:0] sel_mask;

    // Inclusive range compare and grant test
    always_comb begin
        hit      = (blk >= cfg.lo) && (blk <= cfg.hi);
        sel_mask = is_write ? cfg.wmask : cfg.rmask;
        deny     = hit && ((sel_mask & agent) == '0);
    end

endmodule

// File: rtl/imr_filter.sv
// Isolated memory region access filter: a register window of
// NUM_REGIONS regions, parallel range match, and the pass/drop/replace
// decision for each transaction. Assumes one transaction per cycle and
// a one-hot agent identifier.
module imr_filter
    import imr_pkg::*;
#(
    parameter int                  NUM_REGIONS = 8,
    parameter int                  REG_ADDR_W  = 8,
    parameter logic [REG_ADDR_W-1:0] REG_BASE  = 8'h40,
    parameter int                  DATA_W      = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr_en,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    input  logic                  txn_valid,
    input  logic                  txn_write,
    input  logic [31:0]           txn_addr,
    input  logic [MASK_W-1:0]     txn_agent,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic                  mem_wr_en,
    output logic [DATA_W-1:0]     rsp_rdata,
    output logic                  txn_violation
);

    localparam int WIN_LEN = 4 * NUM_REGIONS;

    logic [REG_ADDR_W-1:0]  win_off;
    logic                   in_win;
    imr_word_e              win_word;
    imr_region_t            cfg    [NUM_REGIONS];
    logic [NUM_REGIONS-1:0] hit_vec;
    logic [NUM_REGIONS-1:0] deny_vec;
    logic [NUM_REGIONS-1:0] lock_vec;
    logic [BOUND_W-1:0]     txn_blk;
    logic                   refuse;
    logic                   violation_q;
    logic                   addr_low_unused;

    // Register window decode
    always_comb begin
        win_off  = reg_addr - REG_BASE;
        in_win   = (reg_addr >= REG_BASE) && (win_off < REG_ADDR_W'(WIN_LEN));
        win_word = imr_word_e'(win_off[1:0]);
    end

    assign txn_blk         = txn_addr[31:BLK_LSB];
    assign addr_low_unused = ^txn_addr[BLK_LSB-1:0];

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        logic sel_wr;
        assign sel_wr = reg_wr_en && in_win &&
                        ((win_off >> 2) == REG_ADDR_W'(g));

        imr_region_regs u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (sel_wr),
            .wr_word (win_word),
            .wr_data (reg_wdata),
            .cfg     (cfg[g])
        );

        imr_region_check u_check (
            .cfg      (cfg[g]),
            .blk      (txn_blk),
            .agent    (txn_agent),
            .is_write (txn_write),
            .hit      (hit_vec[g]),
            .deny     (deny_vec[g])
        );

        assign lock_vec[g] = cfg[g].lock;
    end

    // Register readback mux, reserved bits read as zero
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (in_win && ((win_off >> 2) == REG_ADDR_W'(i))) begin
                case (win_word)
                    WORD_LO: reg_rdata = {cfg[i].lock, 7'b0, cfg[i].lo, 2'b0};
                    WORD_HI: reg_rdata = {8'b0, cfg[i].hi, 2'b0};
                    WORD_RD: reg_rdata = cfg[i].rmask;
                    WORD_WR: reg_rdata = cfg[i].wmask;
                    default: reg_rdata = '0;
                endcase
            end
        end
    end

    // Transaction decision: any denying region refuses
    always_comb begin
        refuse    = txn_valid && (|deny_vec);
        mem_wr_en = txn_valid && txn_write && !refuse;
        rsp_rdata = (refuse && !txn_write) ? {DATA_W{1'b1}} : mem_rdata;
    end

    // Violation pulse, one cycle after each refusal
    always_ff @(posedge clk) begin
        if (!rst_n) violation_q <= 1'b0;
        else        violation_q <= refuse;
    end

    assign txn_violation = violation_q;

endmodule

// File: rtl/imr_filter_chk.sv
// Property checker for imr_filter, attached by bind. Observes ports and
// the per-region lock and hit vectors.
module imr_filter_chk
#(
    parameter int NUM_REGIONS = 8,
    parameter int DATA_W      = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   txn_valid,
    input logic                   txn_write,
    input logic                   mem_wr_en,
    input logic [DATA_W-1:0]      mem_rdata,
    input logic [DATA_W-1:0]      rsp_rdata,
    input logic                   txn_violation,
    input logic [NUM_REGIONS-1:0] lock_vec,
    input logic [NUM_REGIONS-1:0] hit_vec
);

    // R4
    wr_needs_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (txn_valid && txn_write));

    // R4
    dropped_wr_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_write && !mem_wr_en) |=> txn_violation);

    // R5
    altered_rd_is_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_write && (rsp_rdata != mem_rdata))
            |-> (rsp_rdata == {DATA_W{1'b1}}));

    // R6
    idle_no_violation_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !txn_valid |=> !txn_violation);

    // R7
    no_hit_no_refusal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && (hit_vec == '0)) |=> !txn_violation);

    // R8
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((lock_vec & $past(lock_vec)) == $past(lock_vec)));

endmodule

bind imr_filter imr_filter_chk #(
    .NUM_REGIONS (NUM_REGIONS),
    .DATA_W      (DATA_W)
) u_imr_filter_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .txn_valid     (txn_valid),
    .txn_write     (txn_write),
    .mem_wr_en     (mem_wr_en),
    .mem_rdata     (mem_rdata),
    .rsp_rdata     (rsp_rdata),
    .txn_violation (txn_violation),
    .lock_vec      (lock_vec),
    .hit_vec       (hit_vec)
);

// File: tb/tb_imr_filter.sv
module tb_imr_filter;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 14;

    // {write, addr, agent, pass}
    localparam logic [65:0] VEC [NV] = '{
        {1'b0, 32'h0000_FFFC, 32'h0000_0002, 1'b1}, // R3 below region 0
        {1'b0, 32'h0001_0000, 32'h0000_0001, 1'b1}, // R5 granted read
        {1'b0, 32'h0001_0000, 32'h0000_0002, 1'b0}, // R3 low edge denied
        {1'b0, 32'h0001_0FFF, 32'h0000_0002, 1'b0}, // R3 high edge inclusive
        {1'b0, 32'h0001_1000, 32'h0000_0002, 1'b1}, // R3 past region 0
        {1'b1, 32'h0001_0800, 32'h0000_0001, 1'b0}, // R7 overlap deny wins
        {1'b1, 32'h0001_0400, 32'h0000_0001, 1'b1}, // R4 granted write
        {1'b1, 32'h0001_1400, 32'h0000_0002, 1'b1}, // R4 granted write
        {1'b1, 32'h0001_17FC, 32'h0000_0001, 1'b0}, // R4 refused write
        {1'b1, 32'h0001_1800, 32'h0000_0001, 1'b1}, // R3 past region 1
        {1'b0, 32'h0000_0100, 32'h4000_0000, 1'b0}, // R9 reset region read
        {1'b0, 32'h0000_0400, 32'h4000_0000, 1'b1}, // R9 second block free
        {1'b1, 32'h0000_0200, 32'h4000_0000, 1'b1}, // R9 reset region write
        {1'b0, 32'h0001_0C00, 32'h0000_1000, 1'b0}  // R5 refused read
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        txn_valid = 1'b0;
    logic        txn_write = 1'b0;
    logic [31:0] txn_addr = '0;
    logic [31:0] txn_agent = '0;
    logic [31:0] mem_rdata = '0;
    logic        mem_wr_en;
    logic [31:0] rsp_rdata;
    logic        txn_violation;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    imr_filter dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr_en     (reg_wr_en),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .txn_valid     (txn_valid),
        .txn_write     (txn_write),
        .txn_addr      (txn_addr),
        .txn_agent     (txn_agent),
        .mem_rdata     (mem_rdata),
        .mem_wr_en     (mem_wr_en),
        .rsp_rdata     (rsp_rdata),
        .txn_violation (txn_violation)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic txn(input string tag, input logic wr, input logic [31:0] a,
                       input logic [31:0] ag, input logic pass);
        @(negedge clk);
        txn_valid = 1'b1; txn_write = wr; txn_addr = a; txn_agent = ag;
        mem_rdata = a ^ 32'h5A5A_0000;
        #1;
        if (wr) check({tag, " R4 mem_wr_en"}, {31'b0, mem_wr_en}, {31'b0, pass});
        else begin
            check({tag, " R5 rsp_rdata"}, rsp_rdata, pass ? (a ^ 32'h5A5A_0000) : 32'hFFFF_FFFF);
            check({tag, " R4 no write on read"}, {31'b0, mem_wr_en}, 32'h0);
        end
        @(negedge clk);
        txn_valid = 1'b0;
        check({tag, " R6 violation"}, {31'b0, txn_violation}, {31'b0, !pass});
        @(negedge clk);
        check({tag, " R6 pulse ends"}, {31'b0, txn_violation}, 32'h0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();

        // R1 reset state
        reg_chk("R1 lo0", 8'h40, 32'h0);
        reg_chk("R1 hi0", 8'h41, 32'h0);
        reg_chk("R1 rmask0", 8'h42, 32'hBFFF_FFFF);
        reg_chk("R1 wmask7", 8'h5F, 32'hFFFF_FFFF);
        check("R6 reset violation", {31'b0, txn_violation}, 32'h0);

        // Program region 0 and overlapping region 1
        reg_wr(8'h40, 32'h0000_0100);
        reg_wr(8'h41, 32'h0000_010C);
        reg_wr(8'h42, 32'h0000_0001);
        reg_wr(8'h43, 32'h0000_0001);
        reg_wr(8'h44, 32'h0000_0108);
        reg_wr(8'h45, 32'h0000_0114);
        reg_wr(8'h46, 32'hFFFF_FFFF);
        reg_wr(8'h47, 32'h0000_0002);
        reg_chk("R1 lo1 programmed", 8'h44, 32'h0000_0108);

        for (int i = 0; i < NV; i++) begin
            txn($sformatf("R3/R7 vector %0d", i), VEC[i][65], VEC[i][64:33],
                VEC[i][32:1], VEC[i][0]);
        end

        // R2 reserved bits
        reg_wr(8'h50, 32'h7FFF_FFFF);
        reg_chk("R2 lo reserved", 8'h50, 32'h00FF_FFFC);
        reg_wr(8'h51, 32'hFFFF_FFFF);
        reg_chk("R2 hi reserved", 8'h51, 32'h00FF_FFFC);
        txn("R3 top block", 1'b0, 32'hFFFF_FFFC, 32'h4000_0000, 1'b0);
        txn("R3 top block granted", 1'b0, 32'hFFFF_FFFC, 32'h0000_0001, 1'b1);
        txn("R3 below top", 1'b0, 32'hFFFF_F800, 32'h4000_0000, 1'b1);

        // R10 out of window
        reg_wr(8'h3F, 32'h5555_5555);
        reg_wr(8'h60, 32'h5555_5555);
        reg_chk("R10 read below", 8'h3F, 32'h0);
        reg_chk("R10 read above", 8'h60, 32'h0);
        reg_chk("R10 region0 intact", 8'h40, 32'h0000_0100);
        reg_chk("R10 region7 intact", 8'h5F, 32'hFFFF_FFFF);

        // R8 lock
        reg_wr(8'h48, 32'h8000_0300);
        reg_chk("R8 lock set", 8'h48, 32'h8000_0300);
        reg_wr(8'h48, 32'h0000_0000);
        reg_chk("R8 lock sticky", 8'h48, 32'h8000_0300);
        reg_wr(8'h49, 32'h0000_0400);
        reg_chk("R8 hi frozen", 8'h49, 32'h0);
        reg_wr(8'h4A, 32'h0);
        reg_chk("R8 rmask frozen", 8'h4A, 32'hBFFF_FFFF);
        reg_wr(8'h4E, 32'h0000_1234);
        reg_chk("R8 neighbour writable", 8'h4E, 32'h0000_1234);
        do_reset();
        reg_chk("R8 lock cleared by reset", 8'h48, 32'h0);
        reg_chk("R1 region0 reset again", 8'h40, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule